// File: doc/BRIEF.md
# Machine-mode trap and interrupt register unit

This block holds the machine-mode trap state of a 32-bit RISC-V core that runs only at machine privilege. It stores the interrupt enable bits, the trap vector, the scratch word, the exception PC and the trap cause. It also owns a per-line enable register for 32 level-sensitive external interrupt requests. Software reaches every register through a single-cycle CSR port: the read data is combinational from the address, a write lands on the next clock edge, and any access to an address that is not implemented raises an illegal flag for that cycle.

The unit combines the timer line, the software line and the filtered external lines with the enable bits and the global interrupt enable, and it raises one interrupt-request flag toward the pipeline. A read-only register reports the lowest-numbered external line that is both asserted and enabled, already scaled to a byte offset into a table of 32-bit words. When the pipeline takes a trap, it pulses a trap strobe with the PC of the trapped instruction. It also says whether the trap is the requested interrupt or an exception, and gives an exception code. The unit supplies the handler address in that same cycle and updates its state on the next edge. A return strobe restores the interrupt enable, and the stored PC is always available as the return address.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset, mstatus (0x300) reads 0x0000_1800, mie (0x304) reads 0, mtvec (0x305) reads the MTVEC_RESET parameter (default 0x0000_0200), mscratch (0x340), mepc (0x341) and mcause (0x342) read 0, and the external enable register (0xbe0) reads 0xFFFF_FFFF. mscratch is a plain 32-bit read/write register.
- R2: csr_illegal is 1 in the same cycle as a read or write of any address other than 0x300, 0x310, 0x304, 0x344, 0x305, 0x340, 0x341, 0x342, 0x343, 0xbe0, 0xfe0 and 0xfe4. A write to 0xfe0 or 0xfe4 is also illegal. An illegal access changes no state, and an unimplemented address reads 0.
- R3: In mstatus, bit 3 (global interrupt enable) and bit 7 (previous enable) are writable, bits 12:11 always read 3, and all other bits read 0. Addresses 0x310 and 0x343 are legal and always read 0.
- R4: On trap_enter, mstatus bit 7 takes the old value of bit 3, and bit 3 becomes 0.
- R5: On mret without trap_enter, mstatus bit 3 takes the old value of bit 7, and bit 7 becomes 1.
- R6: mie has writable bits 3 (software), 7 (timer) and 11 (external), and all other bits read 0. mip (0x344) reads soft_irq at bit 3, timer_irq at bit 7 and, at bit 11, the OR of ext_irq AND the enable register. All other mip bits read 0. A write to mip is legal and has no effect.
- R7: The enable register 0xbe0 is read/write with one bit per external line. Register 0xfe0 reads ext_irq as it is in the current cycle.
- R8: Register 0xfe4 reads (index of the lowest set bit of ext_irq AND enable) shifted left by 2, placed in bits 6:2. It reads 0 when no bit is both asserted and enabled.
- R9: irq_req is 1 exactly when mstatus bit 3 is 1 and at least one of these holds: mie bit 11 with mip bit 11, mie bit 7 with timer_irq, or mie bit 3 with soft_irq.
- R10: The cause of a taken interrupt is 11 if the external source is eligible, otherwise 3 if the software source is eligible, otherwise 7.
- R11: On trap_enter, mcause becomes {1, interrupt cause} when trap_irq is 1 and {0, trap_cause} when it is 0. A software write stores only bit 31 and bits 3:0, and all other bits read 0.
- R12: On trap_enter, mepc takes trap_pc with bit 0 cleared. A software write also clears bit 0. ret_addr always equals mepc.
- R13: mtvec bit 1 always reads 0. trap_target equals mtvec with bits 1:0 cleared. When mtvec bit 0 is 1 and trap_irq is 1, the interrupt cause shifted left by 2 is ORed in, so an external interrupt lands at base + 0x2c.
- R14: A CSR write in a cycle with trap_enter or mret is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_addr | input | 12 | CSR address |
| csr_rd_en | input | 1 | CSR read access this cycle |
| csr_wr_en | input | 1 | CSR write access this cycle |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | Read data of the addressed CSR (combinational) |
| csr_illegal | output | 1 | Access to an unimplemented or read-only address |
| ext_irq | input | 32 | Level-sensitive external interrupt lines |
| timer_irq | input | 1 | Level-sensitive timer interrupt |
| soft_irq | input | 1 | Level-sensitive software interrupt |
| trap_enter | input | 1 | Trap taken this cycle |
| trap_irq | input | 1 | The trap is the requested interrupt (1) or an exception (0) |
| trap_cause | input | 4 | Exception code for a non-interrupt trap |
| trap_pc | input | 32 | PC of the trapped instruction |
| mret | input | 1 | Trap return this cycle |
| irq_req | output | 1 | An interrupt is eligible to be taken |
| trap_target | output | 32 | Handler address for the current trap inputs |
| ret_addr | output | 32 | Return address (mepc) |

## Verification
The hardest state to reach from the ports is a set of interrupt sources that are pending together with different enables, where the arbitration order only shows up in the cause written at the trap and in the vectored target. The stimulus holds several lines asserted at once, turns enables on and off one at a time between traps, and uses vectored mode so that each winning cause appears in trap_target. It also drives a CSR write in the same cycle as a trap strobe and as a return strobe, and then reads back the targeted register.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int XLEN    = 32;
  localparam int CAUSE_W = 4;

  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_STATUSH = 12'h310;
  localparam logic [11:0] A_IE      = 12'h304;
  localparam logic [11:0] A_IP      = 12'h344;
  localparam logic [11:0] A_TVEC    = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_TVAL    = 12'h343;
  localparam logic [11:0] A_XENABLE = 12'hbe0;
  localparam logic [11:0] A_XPEND   = 12'hfe0;
  localparam logic [11:0] A_XLOWEST = 12'hfe4;

  localparam logic [CAUSE_W-1:0] CAUSE_SW  = 4'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_TMR = 4'd7;
  localparam logic [CAUSE_W-1:0] CAUSE_EXT = 4'd11;

  localparam int B_SW   = 3;
  localparam int B_TMR  = 7;
  localparam int B_EXT  = 11;
  localparam int B_GIE  = 3;
  localparam int B_PIE  = 7;

  typedef struct packed {
    logic ext;
    logic tmr;
    logic sw;
  } irq_lines_t;
endpackage

// File: rtl/mtrap_irq_filter.sv
module mtrap_irq_filter #(
  parameter int IRQ_COUNT = 32,
  localparam int IDX_W = (IRQ_COUNT > 1) ? $clog2(IRQ_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_COUNT-1:0] lines,
  input  logic [IRQ_COUNT-1:0] enables,
  output logic [IRQ_COUNT-1:0] active,
  output logic                 any_active,
  output logic [IDX_W-1:0]     lowest_idx
);
  always_comb begin
    active     = lines & enables;
    any_active = |active;
    lowest_idx = '0;
    for (int i = IRQ_COUNT - 1; i >= 0; i--) begin
      if (active[i]) lowest_idx = IDX_W'(i);
    end
  end

  // R8: the reported line is really active, and none below it is
  assert_lowest_is_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_active |-> active[lowest_idx]);
  assert_lowest_is_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_active |-> ((active & ((IRQ_COUNT'(1) << lowest_idx) - IRQ_COUNT'(1))) == '0));
  assert_lowest_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_active |-> (lowest_idx == '0));
endmodule

// File: rtl/mtrap_irq_arbiter.sv
module mtrap_irq_arbiter
  import mtrap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glob_en,
  input  irq_lines_t         enables,
  input  irq_lines_t         pending,
  output logic               irq_req,
  output logic [CAUSE_W-1:0] irq_cause
);
  irq_lines_t live;

  always_comb begin
    live = enables & pending;
    if (live.ext)      irq_cause = CAUSE_EXT;
    else if (live.sw)  irq_cause = CAUSE_SW;
    else if (live.tmr) irq_cause = CAUSE_TMR;
    else               irq_cause = '0;
    irq_req = glob_en & (|live);
  end

  assert_req_needs_global_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glob_en);
  assert_ext_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enables.ext && pending.ext) |-> (irq_cause == CAUSE_EXT));
  assert_sw_over_timer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(enables.ext && pending.ext) && enables.sw && pending.sw) |-> (irq_cause == CAUSE_SW));
endmodule

// File: rtl/mtrap_vector_gen.sv
module mtrap_vector_gen
  import mtrap_pkg::*;
(
  input  logic [XLEN-1:0]    tvec,
  input  logic               take_irq,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    target
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base   = tvec & ~XLEN'(3);
    offset = XLEN'({cause, 2'b00});
    target = (tvec[0] && take_irq) ? (base | offset) : base;
  end
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
  import mtrap_pkg::*;
#(
  parameter int              IRQ_COUNT   = 32,
  parameter logic [XLEN-1:0] MTVEC_RESET = 32'h0000_0200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        csr_addr,
  input  logic               csr_rd_en,
  input  logic               csr_wr_en,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               csr_illegal,
  input  logic [IRQ_COUNT-1:0] ext_irq,
  input  logic               timer_irq,
  input  logic               soft_irq,
  input  logic               trap_enter,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic               mret,
  output logic               irq_req,
  output logic [XLEN-1:0]    trap_target,
  output logic [XLEN-1:0]    ret_addr
);
  localparam int IDX_W = (IRQ_COUNT > 1) ? $clog2(IRQ_COUNT) : 1;

  // reset: asynchronous assertion, synchronous release
  logic rst_s1_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1_q  <= 1'b1;
      rst_int_n <= rst_s1_q;
    end
  end

  // state
  logic                 gie_q, pie_q;
  irq_lines_t           ie_q;
  logic [XLEN-1:0]      tvec_q, scratch_q, epc_q;
  logic                 cause_int_q;
  logic [CAUSE_W-1:0]   cause_code_q;
  logic [IRQ_COUNT-1:0] xen_q;

  // next-state and enables
  logic                 st_en, ie_en, tvec_en, scratch_en, epc_en, cause_en, xen_en;
  logic                 gie_d, pie_d;
  irq_lines_t           ie_d;
  logic [XLEN-1:0]      tvec_d, scratch_d, epc_d;
  logic                 cause_int_d;
  logic [CAUSE_W-1:0]   cause_code_d;
  logic [IRQ_COUNT-1:0] xen_d;

  // decode
  logic implemented, read_only, wr_ok;

  // interrupt path
  logic [IRQ_COUNT-1:0] x_active;
  logic                 x_any;
  logic [IDX_W-1:0]     x_lowest;
  irq_lines_t           pend_lines;
  logic [CAUSE_W-1:0]   irq_cause;

  mtrap_irq_filter #(.IRQ_COUNT(IRQ_COUNT)) u_filter (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lines      (ext_irq),
    .enables    (xen_q),
    .active     (x_active),
    .any_active (x_any),
    .lowest_idx (x_lowest)
  );

  always_comb begin
    pend_lines.ext = x_any;
    pend_lines.tmr = timer_irq;
    pend_lines.sw  = soft_irq;
  end

  mtrap_irq_arbiter u_arbiter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .glob_en   (gie_q),
    .enables   (ie_q),
    .pending   (pend_lines),
    .irq_req   (irq_req),
    .irq_cause (irq_cause)
  );

  mtrap_vector_gen u_vector (
    .tvec     (tvec_q),
    .take_irq (trap_irq),
    .cause    (irq_cause),
    .target   (trap_target)
  );

  assign ret_addr = epc_q;

  // address decode
  always_comb begin
    unique case (csr_addr)
      A_STATUS, A_STATUSH, A_IE, A_IP, A_TVEC, A_SCRATCH, A_EPC, A_CAUSE,
      A_TVAL, A_XENABLE, A_XPEND, A_XLOWEST: implemented = 1'b1;
      default:                               implemented = 1'b0;
    endcase
    read_only   = (csr_addr[11:10] == 2'b11);
    csr_illegal = ((csr_rd_en || csr_wr_en) && !implemented) ||
                  (csr_wr_en && implemented && read_only);
    wr_ok       = csr_wr_en && !csr_illegal && !trap_enter && !mret;
  end

  // read mux
  always_comb begin
    csr_rdata = '0;
    unique case (csr_addr)
      A_STATUS: begin
        csr_rdata[12:11] = 2'b11;
        csr_rdata[B_PIE] = pie_q;
        csr_rdata[B_GIE] = gie_q;
      end
      A_IE: begin
        csr_rdata[B_EXT] = ie_q.ext;
        csr_rdata[B_TMR] = ie_q.tmr;
        csr_rdata[B_SW]  = ie_q.sw;
      end
      A_IP: begin
        csr_rdata[B_EXT] = x_any;
        csr_rdata[B_TMR] = timer_irq;
        csr_rdata[B_SW]  = soft_irq;
      end
      A_TVEC:    csr_rdata = tvec_q;
      A_SCRATCH: csr_rdata = scratch_q;
      A_EPC:     csr_rdata = epc_q;
      A_CAUSE: begin
        csr_rdata[XLEN-1]    = cause_int_q;
        csr_rdata[CAUSE_W-1:0] = cause_code_q;
      end
      A_XENABLE: csr_rdata = XLEN'(xen_q);
      A_XPEND:   csr_rdata = XLEN'(ext_irq);
      A_XLOWEST: csr_rdata = XLEN'({x_lowest, 2'b00});
      default:   csr_rdata = '0;
    endcase
  end

  // next state
  always_comb begin
    st_en = 1'b0;
    gie_d = gie_q;
    pie_d = pie_q;
    if (trap_enter) begin
      st_en = 1'b1;
      pie_d = gie_q;
      gie_d = 1'b0;
    end else if (mret) begin
      st_en = 1'b1;
      gie_d = pie_q;
      pie_d = 1'b1;
    end else if (wr_ok && csr_addr == A_STATUS) begin
      st_en = 1'b1;
      gie_d = csr_wdata[B_GIE];
      pie_d = csr_wdata[B_PIE];
    end

    ie_en  = wr_ok && (csr_addr == A_IE);
    ie_d.ext = csr_wdata[B_EXT];
    ie_d.tmr = csr_wdata[B_TMR];
    ie_d.sw  = csr_wdata[B_SW];

    tvec_en    = wr_ok && (csr_addr == A_TVEC);
    tvec_d     = csr_wdata & ~XLEN'(2);
    scratch_en = wr_ok && (csr_addr == A_SCRATCH);
    scratch_d  = csr_wdata;
    xen_en     = wr_ok && (csr_addr == A_XENABLE);
    xen_d      = csr_wdata[IRQ_COUNT-1:0];

    epc_en = trap_enter || (wr_ok && csr_addr == A_EPC);
    epc_d  = (trap_enter ? trap_pc : csr_wdata) & ~XLEN'(1);

    cause_en = trap_enter || (wr_ok && csr_addr == A_CAUSE);
    if (trap_enter) begin
      cause_int_d  = trap_irq;
      cause_code_d = trap_irq ? irq_cause : trap_cause;
    end else begin
      cause_int_d  = csr_wdata[XLEN-1];
      cause_code_d = csr_wdata[CAUSE_W-1:0];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gie_q        <= 1'b0;
      pie_q        <= 1'b0;
      ie_q         <= '0;
      tvec_q       <= MTVEC_RESET & ~XLEN'(2);
      scratch_q    <= '0;
      epc_q        <= '0;
      cause_int_q  <= 1'b0;
      cause_code_q <= '0;
      xen_q        <= '1;
    end else begin
      if (st_en) begin
        gie_q <= gie_d;
        pie_q <= pie_d;
      end
      if (ie_en)      ie_q      <= ie_d;
      if (tvec_en)    tvec_q    <= tvec_d;
      if (scratch_en) scratch_q <= scratch_d;
      if (epc_en)     epc_q     <= epc_d;
      if (cause_en) begin
        cause_int_q  <= cause_int_d;
        cause_code_q <= cause_code_d;
      end
      if (xen_en)     xen_q     <= xen_d;
    end
  end

  assert_trap_saves_enable_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    trap_enter |=> (!gie_q && (pie_q == $past(gie_q))));
  assert_return_restores_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mret && !trap_enter) |=> (pie_q && (gie_q == $past(pie_q))));
  assert_trap_pc_captured_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    trap_enter |=> (ret_addr == ($past(trap_pc) & ~XLEN'(1))));
  assert_write_dropped_R14: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((trap_enter || mret) && csr_wr_en) |=> ($stable(scratch_q) && $stable(xen_q) && $stable(tvec_q)));
  assert_illegal_no_effect_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (csr_illegal && !trap_enter && !mret) |=> ($stable(scratch_q) && $stable(xen_q) && $stable(gie_q)));
  assert_illegal_needs_access_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    csr_illegal |-> (csr_rd_en || csr_wr_en));
endmodule

// File: tb/mtrap_csr_unit_bench.sv
module mtrap_csr_unit_bench;
  localparam int PERIOD = 10;
  localparam int Q      = PERIOD / 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] csr_addr;
  logic        csr_rd_en, csr_wr_en;
  logic [31:0] csr_wdata, csr_rdata;
  logic        csr_illegal;
  logic [31:0] ext_irq;
  logic        timer_irq, soft_irq;
  logic        trap_enter, trap_irq, mret;
  logic [3:0]  trap_cause;
  logic [31:0] trap_pc;
  logic        irq_req;
  logic [31:0] trap_target, ret_addr;

  always #(PERIOD/2) clk = ~clk;

  mtrap_csr_unit u_mtrap_csr_unit (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd_en(csr_rd_en),
    .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .ext_irq(ext_irq), .timer_irq(timer_irq),
    .soft_irq(soft_irq), .trap_enter(trap_enter), .trap_irq(trap_irq),
    .trap_cause(trap_cause), .trap_pc(trap_pc), .mret(mret),
    .irq_req(irq_req), .trap_target(trap_target), .ret_addr(ret_addr)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  bit          m_gie, m_pie, m_ie_ext, m_ie_tmr, m_ie_sw;
  logic [31:0] m_tvec, m_scr, m_epc, m_cause, m_xen;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_pend();
    return ext_irq & m_xen;
  endfunction

  function automatic int m_icause();
    if (m_ie_ext && (m_pend() != 0)) return 11;
    if (m_ie_sw && soft_irq)         return 3;
    if (m_ie_tmr && timer_irq)       return 7;
    return 0;
  endfunction

  function automatic bit m_legal(logic [11:0] a, bit wr);
    case (a)
      12'h300, 12'h310, 12'h304, 12'h344, 12'h305, 12'h340,
      12'h341, 12'h342, 12'h343, 12'hbe0: return 1'b1;
      12'hfe0, 12'hfe4:                   return !wr;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] v;
    int low;
    v = 0;
    case (a)
      12'h300: v = 32'h1800 | (m_pie ? 32'h80 : 0) | (m_gie ? 32'h8 : 0);
      12'h304: v = (m_ie_ext ? 32'h800 : 0) | (m_ie_tmr ? 32'h80 : 0) | (m_ie_sw ? 32'h8 : 0);
      12'h344: v = ((m_pend() != 0) ? 32'h800 : 0) | (timer_irq ? 32'h80 : 0) | (soft_irq ? 32'h8 : 0);
      12'h305: v = m_tvec;
      12'h340: v = m_scr;
      12'h341: v = m_epc;
      12'h342: v = m_cause;
      12'hbe0: v = m_xen;
      12'hfe0: v = ext_irq;
      12'hfe4: begin
        low = 0;
        for (int i = 31; i >= 0; i--) if (m_pend()[i]) low = i;
        v = low * 4;
      end
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'h300, 12'h310, 12'h343: return "R3";
      12'h304, 12'h344:          return "R6";
      12'hbe0, 12'hfe0:          return "R7";
      12'hfe4:                   return "R8";
      12'h342:                   return "R11";
      12'h341:                   return "R12";
      12'h305:                   return "R13";
      12'h340:                   return "R1";
      default:                   return "R2";
    endcase
  endfunction

  task automatic m_update();
    int c;
    c = m_icause();
    if (trap_enter) begin
      m_epc   = trap_pc & 32'hFFFF_FFFE;
      m_cause = trap_irq ? (32'h8000_0000 | c) : {28'h0, trap_cause};
      m_pie   = m_gie;
      m_gie   = 1'b0;
    end else if (mret) begin
      m_gie = m_pie;
      m_pie = 1'b1;
    end else if (csr_wr_en && m_legal(csr_addr, 1'b1)) begin
      case (csr_addr)
        12'h300: begin m_gie = csr_wdata[3]; m_pie = csr_wdata[7]; end
        12'h304: begin m_ie_ext = csr_wdata[11]; m_ie_tmr = csr_wdata[7]; m_ie_sw = csr_wdata[3]; end
        12'h305: m_tvec = csr_wdata & 32'hFFFF_FFFD;
        12'h340: m_scr  = csr_wdata;
        12'h341: m_epc  = csr_wdata & 32'hFFFF_FFFE;
        12'h342: m_cause = csr_wdata & 32'h8000_000F;
        12'hbe0: m_xen  = csr_wdata;
        default: ;
      endcase
    end
  endtask

  // one clock: compare every output, then advance model with the edge
  task automatic cyc();
    logic [31:0] tgt;
    bit          req;
    #(Q);
    req = m_gie && (m_icause() != 0);
    tgt = m_tvec & 32'hFFFF_FFFC;
    if (m_tvec[0] && trap_irq) tgt = tgt | (m_icause() * 4);
    chk(tag_of(csr_addr), csr_rdata, m_read(csr_addr));
    chk("R2", {31'h0, csr_illegal}, {31'h0, (csr_rd_en || csr_wr_en) && !m_legal(csr_addr, csr_wr_en)});
    chk("R9", {31'h0, irq_req}, {31'h0, req});
    chk("R13", trap_target, tgt);
    chk("R12", ret_addr, m_epc);
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    csr_rd_en = 0; csr_wr_en = 0; csr_wdata = 0; trap_enter = 0;
    trap_irq = 0; mret = 0; trap_cause = 0; trap_pc = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    clear_strobes();
    csr_addr = a; csr_wr_en = 1; csr_wdata = d;
    cyc();
    clear_strobes();
  endtask

  task automatic rd_expect(logic [11:0] a, string tag, logic [31:0] exp);
    clear_strobes();
    csr_addr = a; csr_rd_en = 1;
    #(Q);
    chk(tag, csr_rdata, exp);
    cyc();
    clear_strobes();
  endtask

  task automatic illegal_expect(logic [11:0] a, bit do_wr, string tag, bit exp);
    clear_strobes();
    csr_addr = a; csr_rd_en = !do_wr; csr_wr_en = do_wr; csr_wdata = 32'hFFFF_FFFF;
    #(Q);
    chk(tag, {31'h0, csr_illegal}, {31'h0, exp});
    cyc();
    clear_strobes();
  endtask

  task automatic trap(bit irq, logic [3:0] exc, logic [31:0] pc, logic [31:0] exp_tgt,
                      bit with_wr, logic [11:0] wa, logic [31:0] wd);
    clear_strobes();
    trap_enter = 1; trap_irq = irq; trap_cause = exc; trap_pc = pc;
    csr_wr_en = with_wr; csr_addr = wa; csr_wdata = wd;
    #(Q);
    chk("R13", trap_target, exp_tgt);
    cyc();
    clear_strobes();
  endtask

  task automatic ret(bit with_wr, logic [11:0] wa, logic [31:0] wd);
    clear_strobes();
    mret = 1; csr_wr_en = with_wr; csr_addr = wa; csr_wdata = wd;
    cyc();
    clear_strobes();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_gie = 0; m_pie = 0; m_ie_ext = 0; m_ie_tmr = 0; m_ie_sw = 0;
    m_tvec = 32'h200; m_scr = 0; m_epc = 0; m_cause = 0; m_xen = 32'hFFFF_FFFF;
    rst_n = 0; csr_addr = 0; ext_irq = 0; timer_irq = 0; soft_irq = 0;
    clear_strobes();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_expect(12'h300, "R1", 32'h0000_1800);
    rd_expect(12'h304, "R1", 32'h0);
    rd_expect(12'h305, "R1", 32'h0000_0200);
    rd_expect(12'h340, "R1", 32'h0);
    rd_expect(12'h341, "R1", 32'h0);
    rd_expect(12'h342, "R1", 32'h0);
    rd_expect(12'hbe0, "R1", 32'hFFFF_FFFF);

    // R2 illegal addresses and read-only writes
    illegal_expect(12'h302, 0, "R2", 1);
    illegal_expect(12'h303, 0, "R2", 1);
    illegal_expect(12'h306, 0, "R2", 1);
    illegal_expect(12'h3a0, 0, "R2", 1);
    illegal_expect(12'h3b5, 1, "R2", 1);
    illegal_expect(12'h180, 1, "R2", 1);
    illegal_expect(12'hfe0, 1, "R2", 1);
    illegal_expect(12'hfe4, 1, "R2", 1);
    illegal_expect(12'hbe1, 1, "R2", 1);
    rd_expect(12'hbe0, "R2", 32'hFFFF_FFFF);
    illegal_expect(12'h344, 1, "R6", 0);
    rd_expect(12'h344, "R6", 32'h0);

    // R3 mstatus fields, zero registers
    wr(12'h300, 32'hFFFF_FFFF);
    rd_expect(12'h300, "R3", 32'h0000_1888);
    wr(12'h310, 32'hFFFF_FFFF);
    rd_expect(12'h310, "R3", 32'h0);
    wr(12'h343, 32'hFFFF_FFFF);
    rd_expect(12'h343, "R3", 32'h0);

    // R6 mie fields, mip mirrors lines
    wr(12'h304, 32'hFFFF_FFFF);
    rd_expect(12'h304, "R6", 32'h0000_0888);
    wr(12'h305, 32'h0000_1001);
    soft_irq = 1; timer_irq = 1;
    rd_expect(12'h344, "R6", 32'h0000_0088);

    // R10 software beats timer; R4 then R5
    trap(1, 4'd0, 32'h0000_0400, 32'h0000_100C, 0, 12'h0, 32'h0);
    rd_expect(12'h342, "R10", 32'h8000_0003);
    rd_expect(12'h300, "R4", 32'h0000_1880);
    ret(0, 12'h0, 32'h0);
    rd_expect(12'h300, "R5", 32'h0000_1888);

    // R10 timer alone
    soft_irq = 0;
    trap(1, 4'd0, 32'h0000_0500, 32'h0000_101C, 0, 12'h0, 32'h0);
    rd_expect(12'h342, "R10", 32'h8000_0007);
    ret(0, 12'h0, 32'h0);

    // R7/R8 external lines, R10 external beats software, R13 base+0x2c
    ext_irq = 32'h00F0_0000;
    rd_expect(12'hfe0, "R7", 32'h00F0_0000);
    rd_expect(12'hfe4, "R8", 32'h0000_0050);
    rd_expect(12'h344, "R6", 32'h0000_0880);
    soft_irq = 1;
    trap(1, 4'd0, 32'h0000_0600, 32'h0000_102C, 0, 12'h0, 32'h0);
    rd_expect(12'h342, "R10", 32'h8000_000B);
    rd_expect(12'h300, "R4", 32'h0000_1880);
    ret(0, 12'h0, 32'h0);

    wr(12'hbe0, 32'hFF0F_FFFF);
    rd_expect(12'hbe0, "R7", 32'hFF0F_FFFF);
    rd_expect(12'hfe4, "R8", 32'h0);
    rd_expect(12'h344, "R6", 32'h0000_0088);
    ext_irq = 32'h8100_0000;
    rd_expect(12'hfe4, "R8", 32'h0000_0060);

    // R9 external needs mie bit 11; R10 falls back to software
    wr(12'h304, 32'h0000_0088);
    trap(1, 4'd0, 32'h0000_0700, 32'h0000_100C, 0, 12'h0, 32'h0);
    rd_expect(12'h342, "R10", 32'h8000_0003);
    clear_strobes(); csr_addr = 12'h300;
    #(Q); chk("R9", {31'h0, irq_req}, 32'h0);
    cyc();

    // R11/R12/R13 exception trap in vectored mode goes to base
    trap(0, 4'd2, 32'h0000_1235, 32'h0000_1000, 0, 12'h0, 32'h0);
    rd_expect(12'h341, "R12", 32'h0000_1234);
    rd_expect(12'h342, "R11", 32'h0000_0002);

    // R13 direct mode, bit 1 hardwired
    wr(12'h305, 32'h0000_2003);
    rd_expect(12'h305, "R13", 32'h0000_2001);
    wr(12'h305, 32'h0000_2000);
    wr(12'h300, 32'h0000_0008);
    trap(1, 4'd0, 32'h0000_0800, 32'h0000_2000, 0, 12'h0, 32'h0);

    // R11/R12 software writes
    wr(12'h342, 32'hFFFF_FFFF);
    rd_expect(12'h342, "R11", 32'h8000_000F);
    wr(12'h341, 32'hFFFF_FFFF);
    rd_expect(12'h341, "R12", 32'hFFFF_FFFE);

    // R14 write dropped under trap and under return
    wr(12'h340, 32'h0000_0011);
    trap(0, 4'd11, 32'h0000_0900, 32'h0000_2000, 1, 12'h340, 32'hDEAD_BEEF);
    rd_expect(12'h340, "R14", 32'h0000_0011);
    trap(0, 4'd5, 32'h0000_0A00, 32'h0000_2000, 1, 12'h341, 32'h0000_4444);
    rd_expect(12'h341, "R14", 32'h0000_0A00);
    ret(1, 12'hbe0, 32'h0);
    rd_expect(12'hbe0, "R14", 32'hFF0F_FFFF);

    ext_irq = 0; soft_irq = 0; timer_irq = 0;
    repeat (3) cyc();
    finish_run();
  end
endmodule